// File: doc/BRIEF.md
# Disk Attachment Interrupt Service Engine

This block services interrupts that a disk attachment raises on a small byte/word register port, all in hardware. A pulse on `irq_i` makes the engine read the attachment status register. It goes on only if that register shows an interrupt pending. The engine then reads the interrupt status byte and keeps the device number and the interrupt identifier. If the attachment has a status block ready, the engine pulls it word by word into an eight-word local buffer.

Once the block is in the buffer, the engine classifies the identifier and makes the control writes that follow from it. A transfer-ready interrupt re-arms the control register with DMA on. Completions, errors, resets and aborts get an end-of-interrupt attention sequence. An attention error latches a fatal flag. Reserved identifiers are reported as spurious. For read and write commands the engine also keeps the residual block count from the status block, so host logic can finish the transfer.

Register addresses: control 0 (write), attachment status 1 (read), interrupt status 2 (read), status word 3 (read), attention 4 (write). Each read returns its data on `reg_rdata_i` in the clock cycle after the read strobe.

Top module: `dsk_irq_svc`

## Requirements
- R1: A service starts with one read of the attachment status register. If bit 0 (interrupt pending) is clear, `unclaimed_o` pulses and no other register is read or written.
- R2: The interrupt status byte gives the device number in bits 7:5 and the identifier in bits 3:0. These appear on `dev_o` and `int_id_o`.
- R3: Identifiers 0, 2 and 4 pulse `spurious_o`. They cause no status word read, no write and no result.
- R4: If status bit 1 (status word full) is set after the interrupt status read, the first status word is read. Its bits 15:8 give the block length in words (0 is treated as 1, and anything above 8 as 8). Its bits 4:0 give the command code, shown on `cmd_o`.
- R5: Every later status word is read only after a fresh status read shows bit 1 set. At most 8 words are read. Buffer entries past the length read back as zero. If no word was full, the buffer keeps its previous contents.
- R6: Identifier 0xB (transfer ready) writes 0x03 (interrupt enable bit 0, DMA enable bit 1) to the control register. It posts no result and sends no end-of-interrupt.
- R7: Identifiers 0x1, 0x3, 0x5 and 0x8 post a result with `result_err_o` low. Identifiers 0x9 and 0xA post no result. Every other identifier that is not reserved, 0xB or 0xF posts a result with `result_err_o` high. A result is a one-cycle pulse on `result_valid_o`.
- R8: Every identifier except 0xB, 0xF and the reserved ones ends with three writes in this order: control 0x00, attention `{dev, 5'd2}`, control 0x01.
- R9: On any identifier other than 0xB and the reserved ones, when a block was read and its command code is 1 (read) or 2 (write), `resid_o` takes buffer word 2.
- R10: Identifier 0xF sets `fatal_o`. The flag stays set until reset and no end-of-interrupt is sent.
- R11: After reset the engine is idle. All outputs are zero and the buffer is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Service request from the attachment interrupt line |
| reg_rd_o | output | 1 | Register read strobe |
| reg_wr_o | output | 1 | Register write strobe |
| reg_addr_o | output | 3 | Register address |
| reg_wdata_o | output | 8 | Register write byte |
| reg_rdata_i | input | 16 | Read data, one cycle after the strobe |
| busy_o | output | 1 | Engine is servicing |
| result_valid_o | output | 1 | One-cycle result pulse |
| result_err_o | output | 1 | Result is an error (valid with pulse) |
| dev_o | output | 3 | Device number of last interrupt |
| int_id_o | output | 4 | Identifier of last interrupt |
| cmd_o | output | 5 | Command code of last status block |
| resid_o | output | 16 | Latched residual block count |
| status_block_o | output | 128 | Eight buffered status words, word 0 in bits 15:0 |
| fatal_o | output | 1 | Sticky attention-error flag |
| spurious_o | output | 1 | One-cycle pulse for a reserved identifier |
| unclaimed_o | output | 1 | One-cycle pulse when no interrupt was pending |

## Verification
A table sweeps every identifier class: the four completion codes, reset, abort, transfer ready and several failure codes. Each entry uses different block lengths and a different delay before the status word becomes full. These cases separate the three write sequences and the two result polarities, and show whether the residual is latched, zeroed or left alone. Directed cases cover an empty status register, a reserved identifier and an interrupt with no status block. They also cover a length above eight and an attention error. These show that nothing is touched when it should not be, that the length is clamped, and that the fatal flag stays set until reset.

// File: rtl/dsk_irq_pkg.sv
package dsk_irq_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_ISR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SIFR = 3'd3;
  localparam logic [ADDR_W-1:0] A_ATN  = 3'd4;

  localparam int STAT_INT  = 0;
  localparam int STAT_FULL = 1;

  localparam logic [BYTE_W-1:0] CTRL_OFF    = 8'h00;
  localparam logic [BYTE_W-1:0] CTRL_IE     = 8'h01;
  localparam logic [BYTE_W-1:0] CTRL_IE_DMA = 8'h03;
  localparam logic [4:0]        ATN_EOI     = 5'd2;

  localparam logic [3:0] ID_DONE     = 4'h1;
  localparam logic [3:0] ID_DONE_ECC = 4'h3;
  localparam logic [3:0] ID_DONE_RTY = 4'h5;
  localparam logic [3:0] ID_DONE_WRN = 4'h8;
  localparam logic [3:0] ID_ABORT    = 4'h9;
  localparam logic [3:0] ID_RESET    = 4'hA;
  localparam logic [3:0] ID_XFER_RDY = 4'hB;
  localparam logic [3:0] ID_ATTN_ERR = 4'hF;

  localparam logic [4:0] CMD_READ  = 5'd1;
  localparam logic [4:0] CMD_WRITE = 5'd2;

  typedef struct packed {
    logic spurious;
    logic dma;
    logic eoi;
    logic post_done;
    logic post_err;
    logic fatal;
  } act_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK0, S_ISR, S_CHK1, S_W0, S_WCHK, S_WN, S_ACT, S_EOI_A, S_EOI_B
  } state_e;
endpackage

// File: rtl/dsk_irq_classify.sv
module dsk_irq_classify
  import dsk_irq_pkg::*;
(
  input  logic [3:0] id_i,
  output act_t       act_o
);
  always_comb begin
    act_o = '0;
    case (id_i)
      4'h0, 4'h2, 4'h4: act_o.spurious = 1'b1;
      ID_DONE, ID_DONE_ECC, ID_DONE_RTY, ID_DONE_WRN: begin
        act_o.post_done = 1'b1;
        act_o.eoi       = 1'b1;
      end
      ID_ABORT, ID_RESET: act_o.eoi   = 1'b1;
      ID_XFER_RDY:        act_o.dma   = 1'b1;
      ID_ATTN_ERR:        act_o.fatal = 1'b1;
      default: begin
        act_o.post_err = 1'b1;
        act_o.eoi      = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/dsk_sb_buf.sv
module dsk_sb_buf #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    first_i,
  input  logic                    wr_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [WORD_W-1:0]       data_i,
  output logic [DEPTH*WORD_W-1:0] words_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [WORD_W-1:0] mem_q;
    // first word write restarts the block: other entries drop to zero
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q <= '0;
      else if (first_i)                           mem_q <= (g == 0) ? data_i : '0;
      else if (wr_i && idx_i == IDX_W'(g))        mem_q <= data_i;
    end
    assign words_o[g*WORD_W +: WORD_W] = mem_q;

    if (g > 0) begin : g_chk
      assert_first_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        first_i |=> words_o[g*WORD_W +: WORD_W] == '0);
    end
  end
endmodule

// File: rtl/dsk_irq_seq.sv
module dsk_irq_seq
  import dsk_irq_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int DEPTH     = 8,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic [15:0]       reg_rdata_i,
  input  act_t              act_i,
  input  logic [WORD_W-1:0] resid_word_i,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic [3:0]        cls_id_o,
  output logic              sb_first_o,
  output logic              sb_wr_o,
  output logic [IDX_W-1:0]  sb_idx_o,
  output logic [WORD_W-1:0] sb_data_o,
  output logic              busy_o,
  output logic              result_valid_o,
  output logic              result_err_o,
  output logic [2:0]        dev_o,
  output logic [3:0]        int_id_o,
  output logic [4:0]        cmd_o,
  output logic [WORD_W-1:0] resid_o,
  output logic              fatal_o,
  output logic              spurious_o,
  output logic              unclaimed_o
);
  state_e            state_q;
  logic [IDX_W:0]    cnt_q, len_q, len_eff;
  logic [2:0]        dev_q;
  logic [3:0]        id_q;
  logic [4:0]        cmd_q;
  logic              cmd_ok_q;
  logic [WORD_W-1:0] resid_q;
  logic              res_v_q, res_e_q, fatal_q, spur_q, uncl_q;
  logic              st_int, st_full, more_words;

  assign st_int  = reg_rdata_i[STAT_INT];
  assign st_full = reg_rdata_i[STAT_FULL];

  // clamp length to [1, DEPTH]
  always_comb begin
    if (reg_rdata_i[15:8] == 8'd0)            len_eff = (IDX_W+1)'(1);
    else if (int'(reg_rdata_i[15:8]) > DEPTH) len_eff = (IDX_W+1)'(DEPTH);
    else                                      len_eff = (IDX_W+1)'(reg_rdata_i[15:8]);
  end

  assign more_words = (cnt_q + 1'b1) < len_q;
  assign cls_id_o   = (state_q == S_ISR) ? reg_rdata_i[3:0] : id_q;

  always_comb begin
    reg_rd_o    = 1'b0;
    reg_wr_o    = 1'b0;
    reg_addr_o  = A_STAT;
    reg_wdata_o = CTRL_OFF;
    case (state_q)
      S_IDLE:  reg_rd_o = irq_i;
      S_CHK0:  if (st_int) begin reg_rd_o = 1'b1; reg_addr_o = A_ISR; end
      S_ISR:   reg_rd_o = !act_i.spurious;
      S_CHK1:  if (st_full) begin reg_rd_o = 1'b1; reg_addr_o = A_SIFR; end
      S_W0:    reg_rd_o = (len_eff > (IDX_W+1)'(1));
      S_WCHK: begin
        reg_rd_o = 1'b1;
        if (st_full) reg_addr_o = A_SIFR;
      end
      S_WN:    reg_rd_o = more_words;
      S_ACT: begin
        reg_addr_o = A_CTRL;
        if (act_i.dma)      begin reg_wr_o = 1'b1; reg_wdata_o = CTRL_IE_DMA; end
        else if (act_i.eoi) begin reg_wr_o = 1'b1; reg_wdata_o = CTRL_OFF; end
      end
      S_EOI_A: begin reg_wr_o = 1'b1; reg_addr_o = A_ATN; reg_wdata_o = {dev_q, ATN_EOI}; end
      S_EOI_B: begin reg_wr_o = 1'b1; reg_addr_o = A_CTRL; reg_wdata_o = CTRL_IE; end
      default: ;
    endcase
  end

  assign sb_first_o = (state_q == S_W0);
  assign sb_wr_o    = (state_q == S_WN);
  assign sb_idx_o   = cnt_q[IDX_W-1:0];
  assign sb_data_o  = reg_rdata_i[WORD_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      cnt_q    <= '0;
      len_q    <= '0;
      dev_q    <= '0;
      id_q     <= '0;
      cmd_q    <= '0;
      cmd_ok_q <= 1'b0;
      resid_q  <= '0;
      res_v_q  <= 1'b0;
      res_e_q  <= 1'b0;
      fatal_q  <= 1'b0;
      spur_q   <= 1'b0;
      uncl_q   <= 1'b0;
    end else begin
      res_v_q <= 1'b0;
      spur_q  <= 1'b0;
      uncl_q  <= 1'b0;
      case (state_q)
        S_IDLE: if (irq_i) state_q <= S_CHK0;
        S_CHK0: begin
          uncl_q  <= !st_int;
          state_q <= st_int ? S_ISR : S_IDLE;
        end
        S_ISR: begin
          dev_q    <= reg_rdata_i[7:5];
          id_q     <= reg_rdata_i[3:0];
          cmd_ok_q <= 1'b0;
          spur_q   <= act_i.spurious;
          state_q  <= act_i.spurious ? S_IDLE : S_CHK1;
        end
        S_CHK1: state_q <= st_full ? S_W0 : S_ACT;
        S_W0: begin
          cmd_q    <= reg_rdata_i[4:0];
          cmd_ok_q <= 1'b1;
          len_q    <= len_eff;
          cnt_q    <= (IDX_W+1)'(1);
          state_q  <= (len_eff > (IDX_W+1)'(1)) ? S_WCHK : S_ACT;
        end
        S_WCHK: if (st_full) state_q <= S_WN;
        S_WN: begin
          cnt_q   <= cnt_q + 1'b1;
          state_q <= more_words ? S_WCHK : S_ACT;
        end
        S_ACT: begin
          res_v_q <= act_i.post_done | act_i.post_err;
          res_e_q <= act_i.post_err;
          if (act_i.fatal) fatal_q <= 1'b1;
          if (!act_i.dma && cmd_ok_q && (cmd_q == CMD_READ || cmd_q == CMD_WRITE))
            resid_q <= resid_word_i;
          state_q <= (!act_i.dma && act_i.eoi) ? S_EOI_A : S_IDLE;
        end
        S_EOI_A: state_q <= S_EOI_B;
        S_EOI_B: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o         = (state_q != S_IDLE);
  assign result_valid_o = res_v_q;
  assign result_err_o   = res_e_q;
  assign dev_o          = dev_q;
  assign int_id_o       = id_q;
  assign cmd_o          = cmd_q;
  assign resid_o        = resid_q;
  assign fatal_o        = fatal_q;
  assign spurious_o     = spur_q;
  assign unclaimed_o    = uncl_q;

  assert_unclaimed_after_stat_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unclaimed_o |-> $past(reg_rd_o && reg_addr_o == A_STAT, 2));
  assert_spurious_no_result_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spurious_o |-> !result_valid_o && !reg_wr_o);
  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= (IDX_W+1)'(DEPTH));
  assert_eoi_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && reg_addr_o == A_ATN) |=> (reg_wr_o && reg_addr_o == A_CTRL && reg_wdata_o == CTRL_IE));
  assert_fatal_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o);
endmodule

// File: rtl/dsk_irq_svc.sv
module dsk_irq_svc
  import dsk_irq_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SB_DEPTH  = 8,
  parameter int RESID_IDX = 2,
  localparam int IDX_W    = $clog2(SB_DEPTH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       irq_i,
  output logic                       reg_rd_o,
  output logic                       reg_wr_o,
  output logic [2:0]                 reg_addr_o,
  output logic [7:0]                 reg_wdata_o,
  input  logic [15:0]                reg_rdata_i,
  output logic                       busy_o,
  output logic                       result_valid_o,
  output logic                       result_err_o,
  output logic [2:0]                 dev_o,
  output logic [3:0]                 int_id_o,
  output logic [4:0]                 cmd_o,
  output logic [WORD_W-1:0]          resid_o,
  output logic [SB_DEPTH*WORD_W-1:0] status_block_o,
  output logic                       fatal_o,
  output logic                       spurious_o,
  output logic                       unclaimed_o
);
  act_t              act;
  logic [3:0]        cls_id;
  logic              sb_first, sb_wr;
  logic [IDX_W-1:0]  sb_idx;
  logic [WORD_W-1:0] sb_data;

  dsk_irq_classify u_cls (
    .id_i  (cls_id),
    .act_o (act)
  );

  dsk_sb_buf #(.WORD_W(WORD_W), .DEPTH(SB_DEPTH)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .first_i (sb_first),
    .wr_i    (sb_wr),
    .idx_i   (sb_idx),
    .data_i  (sb_data),
    .words_o (status_block_o)
  );

  dsk_irq_seq #(.WORD_W(WORD_W), .DEPTH(SB_DEPTH)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .irq_i          (irq_i),
    .reg_rdata_i    (reg_rdata_i),
    .act_i          (act),
    .resid_word_i   (status_block_o[RESID_IDX*WORD_W +: WORD_W]),
    .reg_rd_o       (reg_rd_o),
    .reg_wr_o       (reg_wr_o),
    .reg_addr_o     (reg_addr_o),
    .reg_wdata_o    (reg_wdata_o),
    .cls_id_o       (cls_id),
    .sb_first_o     (sb_first),
    .sb_wr_o        (sb_wr),
    .sb_idx_o       (sb_idx),
    .sb_data_o      (sb_data),
    .busy_o         (busy_o),
    .result_valid_o (result_valid_o),
    .result_err_o   (result_err_o),
    .dev_o          (dev_o),
    .int_id_o       (int_id_o),
    .cmd_o          (cmd_o),
    .resid_o        (resid_o),
    .fatal_o        (fatal_o),
    .spurious_o     (spurious_o),
    .unclaimed_o    (unclaimed_o)
  );

  assert_xfer_rdy_no_result_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && reg_addr_o == 3'd0 && reg_wdata_o == 8'h03) |=> !busy_o && !result_valid_o);
endmodule

// File: tb/dsk_irq_svc_test.sv
module dsk_irq_svc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq = 1'b0;
  logic rd, wr, busy, res_v, res_e, fatal, spur, uncl;
  logic [2:0] addr, dev;
  logic [7:0] wdata;
  logic [15:0] rdata = '0;
  logic [3:0] iid;
  logic [4:0] cmd;
  logic [15:0] resid;
  logic [127:0] sb;

  always #10 clk = ~clk;

  dsk_irq_svc uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .reg_rd_o(rd), .reg_wr_o(wr), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_rdata_i(rdata), .busy_o(busy), .result_valid_o(res_v), .result_err_o(res_e),
    .dev_o(dev), .int_id_o(iid), .cmd_o(cmd), .resid_o(resid), .status_block_o(sb),
    .fatal_o(fatal), .spurious_o(spur), .unclaimed_o(uncl)
  );

  // attachment model
  logic        m_intr = 0, m_en = 0;
  logic [7:0]  m_isr = 0;
  logic [15:0] m_words [16];
  int          m_len = 0, m_ptr = 0, m_gap = 0, m_gcnt = 0;
  logic [2:0]  log_a [8];
  logic [7:0]  log_d [8];
  int          wr_n = 0, rd_sifr = 0, rd_other = 0;

  always @(posedge clk) begin
    if (rd) begin
      case (addr)
        3'd1: begin
          rdata <= {14'd0, (m_en && m_ptr < m_len && m_gcnt == 0), m_intr};
          if (m_gcnt != 0) m_gcnt <= m_gcnt - 1;
        end
        3'd2: begin rdata <= {8'd0, m_isr}; m_intr <= 1'b0; rd_other <= rd_other + 1; end
        3'd3: begin
          rdata <= m_words[m_ptr[3:0]]; m_ptr <= m_ptr + 1; m_gcnt <= m_gap;
          rd_sifr <= rd_sifr + 1; rd_other <= rd_other + 1;
        end
        default: rd_other <= rd_other + 1;
      endcase
    end
    if (wr && wr_n < 8) begin
      log_a[wr_n] <= addr; log_d[wr_n] <= wdata; wr_n <= wr_n + 1;
    end
  end

  int res_cnt = 0, spur_cnt = 0, uncl_cnt = 0;
  logic last_err = 0;
  always @(negedge clk) begin
    if (res_v) begin res_cnt <= res_cnt + 1; last_err <= res_e; end
    if (spur) spur_cnt <= spur_cnt + 1;
    if (uncl) uncl_cnt <= uncl_cnt + 1;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setup(input logic intr, input logic [7:0] isr, input bit en, input int len, input int gap);
    @(negedge clk);
    m_intr = intr; m_isr = isr; m_en = en; m_len = len; m_ptr = 0; m_gap = gap; m_gcnt = 0;
    wr_n = 0; rd_sifr = 0; rd_other = 0; res_cnt = 0; spur_cnt = 0; uncl_cnt = 0;
  endtask

  task automatic service();
    @(negedge clk); irq = 1'b1;
    @(negedge clk); irq = 1'b0;
    for (int t = 0; t < 200 && busy; t++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [15:0] wgen(input int i, input int k);
    return 16'hC000 | 16'(i << 8) | 16'(k);
  endfunction

  function automatic logic [127:0] exp_sb(input int i, input int len, input logic [15:0] w0);
    logic [127:0] r = '0;
    for (int k = 0; k < 8; k++)
      if (k < len) r[k*16 +: 16] = (k == 0) ? w0 : wgen(i, k);
    return r;
  endfunction

  typedef struct packed {
    logic [7:0] isr;
    logic [4:0] cmd;
    logic [3:0] len;
    logic [1:0] res;   // 0 none, 1 done, 2 error
    logic       eoi;
    logic       dma;
    logic       rsd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'h21, 5'd1, 4'd4, 2'd1, 1'b1, 1'b0, 1'b1},
    '{8'h03, 5'd2, 4'd3, 2'd1, 1'b1, 1'b0, 1'b1},
    '{8'h45, 5'd9, 4'd5, 2'd1, 1'b1, 1'b0, 1'b0},
    '{8'h28, 5'd1, 4'd8, 2'd1, 1'b1, 1'b0, 1'b1},
    '{8'h0B, 5'd1, 4'd2, 2'd0, 1'b0, 1'b1, 1'b0},
    '{8'h2A, 5'd0, 4'd1, 2'd0, 1'b1, 1'b0, 1'b0},
    '{8'h49, 5'd2, 4'd3, 2'd0, 1'b1, 1'b0, 1'b1},
    '{8'h6C, 5'd2, 4'd6, 2'd2, 1'b1, 1'b0, 1'b1},
    '{8'h0D, 5'd1, 4'd2, 2'd2, 1'b1, 1'b0, 1'b1},
    '{8'hE7, 5'd5, 4'd3, 2'd2, 1'b1, 1'b0, 1'b0},
    '{8'h06, 5'd1, 4'd4, 2'd2, 1'b1, 1'b0, 1'b1}
  };

  initial begin
    logic [15:0] exp_r;
    logic [127:0] keep_sb;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !res_v && !fatal && !spur && !uncl, "R11", {busy, res_v, fatal, spur, uncl}, 0);
    chk(sb == '0 && resid == '0, "R11", sb, 0);
    rst_n = 1'b1;
    exp_r = '0;

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      logic [15:0] w0 = {4'd0, v.len, 3'd0, v.cmd};
      m_words[0] = w0;
      for (int k = 1; k < 16; k++) m_words[k] = wgen(i, k);
      setup(1'b1, v.isr, 1'b1, int'(v.len), i % 3);
      service();
      chk(dev == v.isr[7:5] && iid == v.isr[3:0], "R2", {dev, iid}, {v.isr[7:5], v.isr[3:0]});
      chk(cmd == v.cmd, "R4", cmd, v.cmd);
      chk(sb == exp_sb(i, int'(v.len), w0), "R5", sb, exp_sb(i, int'(v.len), w0));
      chk(res_cnt == (v.res != 0 ? 1 : 0), "R7", res_cnt, v.res != 0);
      if (v.res != 0) chk(last_err == (v.res == 2), "R7", last_err, v.res == 2);
      if (v.dma)
        chk(wr_n == 1 && log_a[0] == 3'd0 && log_d[0] == 8'h03, "R6", {wr_n, log_d[0]}, {32'd1, 8'h03});
      else if (v.eoi)
        chk(wr_n == 3 && log_a[0] == 3'd0 && log_d[0] == 8'h00 && log_a[1] == 3'd4 &&
            log_d[1] == {v.isr[7:5], 5'd2} && log_a[2] == 3'd0 && log_d[2] == 8'h01,
            "R8", {wr_n, log_d[0], log_d[1], log_d[2]}, {32'd3, 8'h00, v.isr[7:5], 5'd2, 8'h01});
      else
        chk(wr_n == 0, "R8", wr_n, 0);
      if (v.rsd) exp_r = (v.len > 2) ? wgen(i, 2) : 16'h0;
      chk(resid == exp_r, "R9", resid, exp_r);
    end

    // R1 nothing pending
    setup(1'b0, 8'h21, 1'b1, 3, 0);
    keep_sb = sb;
    service();
    chk(uncl_cnt == 1, "R1", uncl_cnt, 1);
    chk(wr_n == 0 && rd_other == 0 && res_cnt == 0, "R1", {wr_n, rd_other, res_cnt}, 0);
    chk(sb == keep_sb, "R1", sb, keep_sb);

    // R3 reserved identifier 2
    setup(1'b1, 8'h22, 1'b1, 3, 0);
    service();
    chk(spur_cnt == 1 && res_cnt == 0, "R3", {spur_cnt, res_cnt}, {32'd1, 32'd0});
    chk(wr_n == 0 && rd_sifr == 0 && sb == keep_sb, "R3", {wr_n, rd_sifr}, 0);

    // R5 no status block: buffer and residual untouched, still completes
    setup(1'b1, 8'h41, 1'b0, 3, 0);
    service();
    chk(rd_sifr == 0 && sb == keep_sb, "R5", sb, keep_sb);
    chk(resid == exp_r && res_cnt == 1 && !last_err && wr_n == 3, "R9", {resid, res_cnt, wr_n}, {exp_r, 32'd1, 32'd3});

    // R4 length above the buffer depth is clamped
    m_words[0] = {8'd12, 3'd0, 5'd2};
    for (int k = 1; k < 16; k++) m_words[k] = wgen(20, k);
    setup(1'b1, 8'h01, 1'b1, 12, 1);
    service();
    chk(rd_sifr == 8, "R4", rd_sifr, 8);
    chk(sb == exp_sb(20, 8, {8'd12, 3'd0, 5'd2}), "R5", sb, exp_sb(20, 8, {8'd12, 3'd0, 5'd2}));
    chk(resid == wgen(20, 2), "R9", resid, wgen(20, 2));

    // R10 attention error: sticky fatal, no end-of-interrupt
    m_words[0] = {8'd1, 3'd0, 5'd0};
    setup(1'b1, 8'h6F, 1'b1, 1, 0);
    service();
    chk(fatal && wr_n == 0 && res_cnt == 0, "R10", {fatal, wr_n, res_cnt}, {1'b1, 32'd0, 32'd0});
    m_words[0] = {8'd1, 3'd0, 5'd0};
    setup(1'b1, 8'h01, 1'b1, 1, 0);
    service();
    chk(fatal && res_cnt == 1, "R10", {fatal, res_cnt}, {1'b1, 32'd1});
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(!fatal && sb == '0 && resid == '0, "R11", {fatal, resid}, 0);
    rst_n = 1'b1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule